// File: doc/BRIEF.md
# DMA Channel Byte-Count Tracker

This block keeps the remaining transfer length of one DMA channel. Software writes a starting byte count through a load port. Each time the engine finishes the address phase of a write transfer, the count drops by the size of that access. When the count reaches zero, a sticky completion flag sets and the channel's active indication falls on the same clock edge. Software clears the flag with a write-one-to-clear strobe, or by loading a fresh nonzero count.

A mode input sets the counter to 24 bits or 16 bits. In the narrow mode the top byte of the count always reads zero, and a load takes only the low 16 bits of the written value. If an access is larger than the bytes that remain, the counter stops at zero instead of wrapping. The flag still sets, and a one-cycle error pulse reports the overrun. The block has no bus mastering, address generation or arbitration. It only counts.

Top module: `dma_bytecount`

## Requirements
- R1: After a synchronous active-high reset, `count` is 0 and `done`, `active` and `size_err` are all low.
- R2: A load (`load_en` high) writes `load_data` into the count. With `wide_mode` high all 24 bits are taken. With `wide_mode` low only bits 15:0 are taken and bits 23:16 become zero.
- R3: The count changes only on a clock where `addr_done` and `addr_write` are both high. A read address phase (`addr_write` low) or a cycle without a completed address phase leaves the count unchanged.
- R4: The decrement follows `xfer_size`: code 0 (byte) subtracts 1, code 1 (16-bit) subtracts 2, code 2 (32-bit) subtracts 4 and code 3 (line) subtracts 16.
- R5: `active` is high exactly while the count is nonzero. When a decrement makes the count exactly zero, `done` rises on the same edge that `active` falls.
- R6: When the step is larger than the remaining nonzero count, the count becomes 0, `done` sets, and `size_err` is high for exactly the one following cycle.
- R7: `done` stays set until `done_clr` is high or a nonzero value is loaded. Loading zero leaves `done` as it was. If a completion and `done_clr` fall on the same cycle, `done` ends up set.
- R8: When a load and a write address-phase strobe fall on the same cycle, the loaded value is kept and that decrement is dropped.
- R9: While `wide_mode` is low, bits 23:16 of `count` read zero. The register also truncates to 16 bits on the next edge, so any upper bits are gone when wide mode returns.
- R10: A write strobe while the count is zero has no effect: the count stays 0, `done` keeps its value and `size_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1: 24-bit count, 0: 16-bit count |
| addr_done | input | 1 | Address phase completed successfully this cycle |
| addr_write | input | 1 | The completed address phase belongs to a write |
| xfer_size | input | 2 | Access size code: 0 byte, 1 16-bit, 2 32-bit, 3 line |
| load_en | input | 1 | Software load strobe |
| load_data | input | 24 | Count value to load |
| done_clr | input | 1 | Write-one-to-clear strobe for `done` |
| count | output | 24 | Remaining byte count |
| done | output | 1 | Sticky block-complete flag |
| active | output | 1 | Count is nonzero |
| size_err | output | 1 | One-cycle pulse on an overrun decrement |

## Verification
The counter is driven through all four size codes, from both large and small starting values. This separates a wrong step amount from a wrong strobe qualification. Read strobes, missing strobes and strobes at zero all look the same as idle cycles to a correct design, so each one isolates a gating fault. Loads that coincide with strobes, with `done_clr`, and with mode switches separate the priority rules. A long random phase with small load values reaches exact-zero and overrun endings many times in both width modes.

// File: rtl/dmabc_pkg.sv
package dmabc_pkg;

    localparam int STEP_W = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic hit_zero;
        logic overrun;
        logic load_nz;
    } cnt_evt_t;

    function automatic logic [STEP_W-1:0] step_of(input xfer_size_e sz);
        case (sz)
            SZ_BYTE: step_of = 5'd1;
            SZ_HALF: step_of = 5'd2;
            SZ_WORD: step_of = 5'd4;
            default: step_of = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/bc_step_decode.sv
module bc_step_decode
    import dmabc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [1:0]       size_code,
    output logic [CNT_W-1:0] step
);
    logic [STEP_W-1:0] raw;

    always_comb begin
        raw  = step_of(xfer_size_e'(size_code));
        step = CNT_W'(raw);
    end
endmodule

// File: rtl/bc_counter.sv
module bc_counter
    import dmabc_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wide,
    input  logic             dec_req,
    input  logic [CNT_W-1:0] step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output cnt_evt_t         evt
);
    localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CNT_W-1:0] WIDE_MASK   = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d, mask, cur, ld_m;
    logic             live, dec_ok;

    always_comb begin
        mask   = wide ? WIDE_MASK : NARROW_MASK;
        cur    = cnt_q & mask;
        ld_m   = load_val & mask;
        live   = (cur != '0);
        dec_ok = dec_req && !load && live;

        evt.hit_zero = dec_ok && (step == cur);
        evt.overrun  = dec_ok && (step > cur);
        evt.load_nz  = load && (ld_m != '0);

        if (load)
            cnt_d = ld_m;
        else if (evt.overrun)
            cnt_d = '0;
        else if (dec_ok)
            cnt_d = cur - step;
        else
            cnt_d = cur;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cur;
endmodule

// File: rtl/bc_status.sv
module bc_status
    import dmabc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_evt_t evt,
    input  logic     clr,
    output logic     done,
    output logic     err_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= evt.overrun;
            if (evt.hit_zero || evt.overrun)
                done <= 1'b1;
            else if (evt.load_nz || clr)
                done <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_bytecount.sv
module dma_bytecount
    import dmabc_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wide_mode,
    input  logic             addr_done,
    input  logic             addr_write,
    input  logic [1:0]       xfer_size,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_data,
    input  logic             done_clr,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             active,
    output logic             size_err
);
    logic [CNT_W-1:0] step;
    cnt_evt_t         evt;
    logic             dec_req;

    assign dec_req = addr_done && addr_write;

    bc_step_decode #(.CNT_W(CNT_W)) u_step (
        .size_code (xfer_size),
        .step      (step)
    );

    bc_counter #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .wide     (wide_mode),
        .dec_req  (dec_req),
        .step     (step),
        .load     (load_en),
        .load_val (load_data),
        .cnt      (count),
        .evt      (evt)
    );

    bc_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .clr       (done_clr),
        .done      (done),
        .err_pulse (size_err)
    );

    assign active = (count != '0);
endmodule

// File: rtl/dma_bytecount_chk.sv
module dma_bytecount_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             wide_mode,
    input logic             addr_done,
    input logic             addr_write,
    input logic             load_en,
    input logic [CNT_W-1:0] load_data,
    input logic             done_clr,
    input logic [CNT_W-1:0] count,
    input logic             done,
    input logic             active,
    input logic             size_err
);
    // R6
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        size_err |=> !size_err);

    // R5
    done_rise_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !active);

    // R3
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(addr_done && addr_write) && !load_en) ##1 $stable(wide_mode) |-> $stable(count));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && wide_mode) ##1 wide_mode |-> count == $past(load_data));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !done_clr && !load_en) |=> done);

    // R10
    idle_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !load_en) |=> !size_err);
endmodule

bind dma_bytecount dma_bytecount_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_dma_bytecount.sv
module tb_dma_bytecount;
    logic        clk = 1'b0;
    logic        rst;
    logic        wide_mode, addr_done, addr_write, load_en, done_clr;
    logic [1:0]  xfer_size;
    logic [23:0] load_data;
    logic [23:0] count;
    logic        done, active, size_err;

    int checks = 0;
    int errors = 0;
    int m_cnt;
    bit m_done, m_err;

    always #4 clk = ~clk;

    dma_bytecount dut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .addr_done(addr_done),
        .addr_write(addr_write), .xfer_size(xfer_size), .load_en(load_en),
        .load_data(load_data), .done_clr(done_clr), .count(count),
        .done(done), .active(active), .size_err(size_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int msk, ec;
        msk = wide_mode ? 32'hFFFFFF : 32'hFFFF;
        ec  = m_cnt & msk;
        chk(tag, "count", int'(count), ec);
        chk(tag, "done", int'(done), int'(m_done));
        chk(tag, "active", int'(active), int'(ec != 0));
        chk(tag, "size_err", int'(size_err), int'(m_err));
    endtask

    task automatic model(input bit w, input bit ad, input bit aw, input int sz,
                         input bit le, input int ld, input bit clr);
        int msk, cm, st, nv;
        msk = w ? 32'hFFFFFF : 32'hFFFF;
        cm  = m_cnt & msk;
        st  = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 16;
        m_err = 1'b0;
        if (le) begin
            nv = ld & msk;
            m_cnt = nv;
            if (nv != 0 || clr) m_done = 1'b0;
        end else if (ad && aw && cm != 0) begin
            if (st >= cm) begin
                m_err  = (st > cm);
                m_cnt  = 0;
                m_done = 1'b1;
            end else begin
                m_cnt = cm - st;
                if (clr) m_done = 1'b0;
            end
        end else begin
            m_cnt = cm;
            if (clr) m_done = 1'b0;
        end
    endtask

    task automatic cyc(input bit w, input bit ad, input bit aw, input int sz,
                       input bit le, input int ld, input bit clr, input string tag);
        wide_mode = w; addr_done = ad; addr_write = aw; xfer_size = 2'(sz);
        load_en = le; load_data = 24'(ld); done_clr = clr;
        model(w, ad, aw, sz, le, ld, clr);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wide_mode = 1'b1; addr_done = 0; addr_write = 0; xfer_size = 0;
        load_en = 0; load_data = 0; done_clr = 0;
        m_cnt = 0; m_done = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1");

        cyc(1, 0, 0, 0, 1, 24'h012345, 0, "R2");
        cyc(1, 1, 0, 3, 0, 0, 0, "R3");   // read address phase
        cyc(1, 0, 1, 3, 0, 0, 0, "R3");   // no completed phase
        cyc(1, 1, 1, 0, 0, 0, 0, "R4");
        cyc(1, 1, 1, 1, 0, 0, 0, "R4");
        cyc(1, 1, 1, 2, 0, 0, 0, "R4");
        cyc(1, 1, 1, 3, 0, 0, 0, "R4");
        cyc(0, 0, 0, 0, 1, 24'h010203, 0, "R2");
        cyc(0, 1, 1, 3, 1, 20, 0, "R8");
        cyc(0, 1, 1, 3, 0, 0, 0, "R4");
        cyc(0, 1, 1, 2, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, 0, 0, "R7");
        cyc(0, 1, 1, 3, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 1, "R7");
        cyc(1, 0, 0, 0, 1, 3, 0, "R2");
        cyc(1, 1, 1, 2, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, 1, 0, 0, "R7");
        cyc(1, 0, 0, 0, 1, 5, 0, "R7");
        cyc(1, 0, 0, 0, 1, 24'h100000, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, "R9");
        cyc(1, 0, 0, 0, 0, 0, 0, "R9");
        cyc(1, 0, 0, 0, 1, 1, 0, "R2");
        cyc(1, 1, 1, 0, 0, 0, 1, "R7");
        cyc(1, 0, 0, 0, 0, 0, 0, "R7");

        for (int i = 0; i < 3000; i++) begin
            bit w, ad, aw, le, clr;
            int sz, ld;
            w   = ($urandom_range(0, 9) != 0) ? (i / 500) % 2 == 0 : ~((i / 500) % 2 == 0);
            ad  = $urandom_range(0, 3) != 0;
            aw  = $urandom_range(0, 4) != 0;
            sz  = $urandom_range(0, 3);
            le  = $urandom_range(0, 11) == 0;
            ld  = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 24'hFFFFFF) : $urandom_range(0, 40);
            clr = $urandom_range(0, 9) == 0;
            cyc(w, ad, aw, sz, le, ld, clr, "R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule